// File: doc/BRIEF.md
# Paged Program Counter

This block holds the 13-bit instruction address of a small 8-bit controller core. Each instruction cycle the address moves on by one, or it is replaced by a new address from one of four sources. Those sources are, highest priority first: the interrupt vector, a return address from the call stack, a jump or call target taken from the opcode, and an ALU result written into the low byte. The low byte can be read back at any time. The upper five bits can never be written directly. They come from a separate page latch that software loads with an explicit register write.

The page latch feeds the new address in two different ways. A write to the low byte takes all five latch bits as address bits 12:8. A jump or call takes only latch bits 4:3 as address bits 12:11, because the opcode already supplies bits 10:0. No ALU carry ever reaches bits 12:8. A computed jump therefore stays inside the current 256-word page and wraps within it. The call stack, the decoder, the ALU and program memory sit outside the block and drive its strobes.

Top module: `paged_pc`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the address to 0x0000 and the page latch to 0x00. It stays cleared while reset is held.
- R2: When no load strobe is active, the address goes up by one per clock and wraps from 0x1FFF to 0x0000.
- R3: pcl_rdata always equals address bits 7:0.
- R4: A low-byte write (lo_wr) loads bits 7:0 from lo_wdata and bits 12:8 from the latch value held before that edge. A latch write in the same cycle does not affect this load.
- R5: A computed jump never carries into bits 12:8. Bits 12:8 come only from the latch, so a table index that passes 0xFF wraps inside the page.
- R6: A jump or call (jmp_take) loads bits 10:0 from jmp_tgt and bits 12:11 from latch bits 4:3. Latch bits 2:0 have no effect.
- R7: A return (ret_take) loads all 13 bits from ret_addr and leaves the latch unchanged.
- R8: An interrupt (irq_take) loads 0x0004 and leaves the latch unchanged.
- R9: When several strobes are active, the source is chosen in this order: interrupt, return, jump, low-byte write, increment.
- R10: The latch changes only on hi_wr. It takes hi_wdata at that edge, and every later load uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Vector to the interrupt address |
| ret_take | input | 1 | Load a return address |
| ret_addr | input | 13 | Return address from the stack |
| jmp_take | input | 1 | Jump or call to an opcode target |
| jmp_tgt | input | 11 | Opcode target field |
| lo_wr | input | 1 | Write the ALU result to the low byte |
| lo_wdata | input | 8 | ALU result |
| hi_wr | input | 1 | Write the page latch |
| hi_wdata | input | 5 | New page latch value |
| pc_addr | output | 13 | Current instruction address |
| pcl_rdata | output | 8 | Readable low byte of the address |

## Verification
Every load, every increment and every latch write appears at the ports after exactly one rising edge. An address change is visible on the same edge that samples its strobe. A latch change shows up only in the next low-byte write or jump that uses it. The bench drives each stimulus on a falling edge, keeps it for one rising edge, samples on the following falling edge, and only then releases the strobes. The latch has no read path, so it is observed by a later low-byte write or jump after the operation under test.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

   // Source of the next instruction address
   typedef enum logic [2:0] {
      SRC_INC = 3'd0,
      SRC_LOW = 3'd1,
      SRC_JMP = 3'd2,
      SRC_RET = 3'd3,
      SRC_VEC = 3'd4
   } pc_src_e;

endpackage

// File: rtl/pgpc_page_latch.sv
module pgpc_page_latch #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("pgpc_page_latch: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata;
   end

   // R10
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));

   // R10
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> q == $past(wdata));

endmodule

// File: rtl/pgpc_src_arb.sv
module pgpc_src_arb
   import pgpc_pkg::*;
(
   input  logic    irq,
   input  logic    ret,
   input  logic    jmp,
   input  logic    low,
   output pc_src_e src
);

   // R9: fixed priority, interrupt first
   always_comb begin
      if (irq)      src = SRC_VEC;
      else if (ret) src = SRC_RET;
      else if (jmp) src = SRC_JMP;
      else if (low) src = SRC_LOW;
      else          src = SRC_INC;
   end

endmodule

// File: rtl/pgpc_next_addr.sv
module pgpc_next_addr
   import pgpc_pkg::*;
#(
   parameter int PC_W     = 13,
   parameter int LO_W     = 8,
   parameter int JMP_W    = 11,
   parameter int VEC_ADDR = 4
) (
   input  pc_src_e              src,
   input  logic [PC_W-1:0]      pc_cur,
   input  logic [PC_W-LO_W-1:0] page,
   input  logic [LO_W-1:0]      lo_data,
   input  logic [JMP_W-1:0]     jmp_tgt,
   input  logic [PC_W-1:0]      ret_addr,
   output logic [PC_W-1:0]      nxt
);

   localparam int LAT_W = PC_W - LO_W;
   localparam logic [PC_W-1:0] VEC_A = PC_W'(VEC_ADDR);
   localparam logic [PC_W-1:0] ONE   = PC_W'(1);

   logic [PC_W-1:0] a_inc;
   logic [PC_W-1:0] a_low;
   logic [PC_W-1:0] a_jmp;

   // Plain increment; carry out of the top bit is dropped (R2)
   assign a_inc = pc_cur + ONE;

   // Low-byte write: the whole latch forms the page, no ALU carry (R4, R5)
   assign a_low = {page, lo_data};

   // Jump: opcode field below JMP_W, matching latch bits above it (R6)
   for (genvar i = 0; i < PC_W; i++) begin : g_jbit
      if (i < JMP_W) begin : g_op
         assign a_jmp[i] = jmp_tgt[i];
      end else begin : g_pg
         assign a_jmp[i] = page[i-LO_W];
      end
   end

   always_comb begin
      case (src)
         SRC_VEC: nxt = VEC_A;
         SRC_RET: nxt = ret_addr;
         SRC_JMP: nxt = a_jmp;
         SRC_LOW: nxt = a_low;
         default: nxt = a_inc;
      endcase
   end

   if (LAT_W < 1) begin : g_bad_lat
      $error("pgpc_next_addr: latch width must be positive");
   end

endmodule

// File: rtl/paged_pc.sv
module paged_pc
   import pgpc_pkg::*;
#(
   parameter int PC_W     = 13,
   parameter int LO_W     = 8,
   parameter int JMP_W    = 11,
   parameter int VEC_ADDR = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 irq_take,
   input  logic                 ret_take,
   input  logic [PC_W-1:0]      ret_addr,
   input  logic                 jmp_take,
   input  logic [JMP_W-1:0]     jmp_tgt,
   input  logic                 lo_wr,
   input  logic [LO_W-1:0]      lo_wdata,
   input  logic                 hi_wr,
   input  logic [PC_W-LO_W-1:0] hi_wdata,
   output logic [PC_W-1:0]      pc_addr,
   output logic [LO_W-1:0]      pcl_rdata
);

   localparam int LAT_W = PC_W - LO_W;
   localparam int JHI_W = PC_W - JMP_W;

   // Elaboration-time parameter checks
   if (PC_W <= LO_W) begin : g_bad_pc
      $error("paged_pc: PC_W must exceed LO_W");
   end
   if (JMP_W < LO_W || JMP_W >= PC_W) begin : g_bad_jmp
      $error("paged_pc: JMP_W must lie in [LO_W, PC_W)");
   end
   if (VEC_ADDR < 0 || VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
      $error("paged_pc: VEC_ADDR out of range");
   end

   logic [LAT_W-1:0] page_q;
   logic [PC_W-1:0]  pc_q;
   logic [PC_W-1:0]  pc_d;
   pc_src_e          src;

   pgpc_page_latch #(.W(LAT_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (hi_wr),
      .wdata (hi_wdata),
      .q     (page_q)
   );

   pgpc_src_arb u_arb (
      .irq (irq_take),
      .ret (ret_take),
      .jmp (jmp_take),
      .low (lo_wr),
      .src (src)
   );

   pgpc_next_addr #(
      .PC_W     (PC_W),
      .LO_W     (LO_W),
      .JMP_W    (JMP_W),
      .VEC_ADDR (VEC_ADDR)
   ) u_next (
      .src      (src),
      .pc_cur   (pc_q),
      .page     (page_q),
      .lo_data  (lo_wdata),
      .jmp_tgt  (jmp_tgt),
      .ret_addr (ret_addr),
      .nxt      (pc_d)
   );

   // R1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc_addr   = pc_q;
   assign pcl_rdata = pc_q[LO_W-1:0];

   // R2
   inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_take || ret_take || jmp_take || lo_wr) |=> pc_q == $past(pc_q) + PC_W'(1));

   // R8, R9
   vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> pc_q == PC_W'(VEC_ADDR));

   // R7, R9
   ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_take && !irq_take) |=> pc_q == $past(ret_addr));

   // R6, R9
   jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_take && !ret_take && !irq_take) |=>
         (pc_q[JMP_W-1:0] == $past(jmp_tgt)) &&
         (pc_q[PC_W-1:JMP_W] == $past(page_q[LAT_W-1:LAT_W-JHI_W])));

   // R4, R5
   low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !jmp_take && !ret_take && !irq_take) |=>
         (pc_q[LO_W-1:0] == $past(lo_wdata)) && (pc_q[PC_W-1:LO_W] == $past(page_q)));

endmodule

// File: tb/sim_paged_pc.sv
module sim_paged_pc;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq_take, ret_take, jmp_take, lo_wr, hi_wr;
   logic [12:0] ret_addr;
   logic [10:0] jmp_tgt;
   logic [7:0]  lo_wdata;
   logic [4:0]  hi_wdata;
   logic [12:0] pc_addr;
   logic [7:0]  pcl_rdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   paged_pc u0 (
      .clk(clk), .rst_n(rst_n),
      .irq_take(irq_take), .ret_take(ret_take), .ret_addr(ret_addr),
      .jmp_take(jmp_take), .jmp_tgt(jmp_tgt),
      .lo_wr(lo_wr), .lo_wdata(lo_wdata),
      .hi_wr(hi_wr), .hi_wdata(hi_wdata),
      .pc_addr(pc_addr), .pcl_rdata(pcl_rdata)
   );

   task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
      end
   endtask

   // Compare the address and its low-byte mirror (R3)
   task automatic chk_pc(input string req, input logic [12:0] exp);
      chk(req, pc_addr, exp);
      chk("R3 low byte mirror", {5'd0, pcl_rdata}, {5'd0, exp[7:0]});
   endtask

   task automatic idle();
      irq_take = 0; ret_take = 0; jmp_take = 0; lo_wr = 0; hi_wr = 0;
      ret_addr = '0; jmp_tgt = '0; lo_wdata = '0; hi_wdata = '0;
   endtask

   // Apply strobes for one rising edge; return at the next falling edge
   task automatic op(input logic irq, input logic ret, input logic [12:0] ra,
                     input logic jmp, input logic [10:0] jt,
                     input logic lo, input logic [7:0] ld,
                     input logic hi, input logic [4:0] hd);
      irq_take = irq; ret_take = ret; ret_addr = ra;
      jmp_take = jmp; jmp_tgt = jt; lo_wr = lo; lo_wdata = ld;
      hi_wr = hi; hi_wdata = hd;
      @(negedge clk);
      idle();
   endtask

   task automatic nop();     op(0,0,0, 0,0, 0,0, 0,0); endtask
   task automatic setpg(input logic [4:0] v);  op(0,0,0, 0,0, 0,0, 1,v); endtask
   task automatic wlow(input logic [7:0] v);   op(0,0,0, 0,0, 1,v, 0,0); endtask
   task automatic jump(input logic [10:0] t);  op(0,0,0, 1,t, 0,0, 0,0); endtask
   task automatic retn(input logic [12:0] a);  op(0,1,a, 0,0, 0,0, 0,0); endtask

   task automatic t_reset();
      rst_n = 0; idle();
      repeat (2) @(negedge clk);
      chk_pc("R1 address held at zero in reset", 13'h0000);
      rst_n = 1;
      nop();
      chk_pc("R2 first increment after reset", 13'h0001);
      wlow(8'h33);
      chk_pc("R1 latch cleared by reset", 13'h0033);
   endtask

   task automatic t_count();
      for (int i = 1; i <= 4; i++) begin
         nop();
         chk_pc("R2 increment", 13'h0033 + 13'(i));
      end
      retn(13'h1FFE);
      chk_pc("R7 return load", 13'h1FFE);
      nop();
      chk_pc("R2 increment to top", 13'h1FFF);
      nop();
      chk_pc("R2 wrap to zero", 13'h0000);
   endtask

   task automatic t_lowbyte();
      setpg(5'h15);
      wlow(8'hA7);
      chk_pc("R4 low write with latch", 13'h15A7);
      op(0,0,0, 0,0, 1,8'h10, 1,5'h0A);
      chk_pc("R4 same-cycle latch write uses old page", 13'h1510);
      wlow(8'h20);
      chk_pc("R10 new latch applied afterwards", 13'h0A20);
   endtask

   task automatic t_page();
      setpg(5'h03);
      wlow(8'hFE);
      nop();
      chk_pc("R2 increment inside page", 13'h03FF);
      wlow(8'(8'hFF + 8'h03));
      chk_pc("R5 computed jump wraps in page", 13'h0302);
   endtask

   task automatic t_jump();
      setpg(5'h0A);
      jump(11'h5C3);
      chk_pc("R6 jump page bits from latch 4:3", 13'h0DC3);
      setpg(5'h17);
      jump(11'h7FF);
      chk_pc("R6 latch bits 2:0 ignored", 13'h17FF);
   endtask

   task automatic t_ret_irq();
      setpg(5'h1F);
      retn(13'h0ABC);
      chk_pc("R7 return address", 13'h0ABC);
      wlow(8'h00);
      chk_pc("R7 latch unchanged by return", 13'h1F00);
      op(1,0,0, 0,0, 0,0, 0,0);
      chk_pc("R8 interrupt vector", 13'h0004);
      wlow(8'h11);
      chk_pc("R8 latch unchanged by interrupt", 13'h1F11);
   endtask

   task automatic t_prio();
      setpg(5'h08);
      op(1,1,13'h1234, 1,11'h155, 1,8'h66, 0,0);
      chk_pc("R9 interrupt wins", 13'h0004);
      op(0,1,13'h1234, 1,11'h155, 1,8'h66, 0,0);
      chk_pc("R9 return over jump", 13'h1234);
      op(0,0,0, 1,11'h155, 1,8'h66, 0,0);
      chk_pc("R9 jump over low write", 13'h0955);
      op(0,0,0, 0,0, 1,8'h66, 0,0);
      chk_pc("R9 low write over increment", 13'h0866);
   endtask

   task automatic t_rereset();
      setpg(5'h1B);
      @(negedge clk);
      rst_n = 0;
      #1;
      chk_pc("R1 async clear", 13'h0000);
      @(negedge clk);
      rst_n = 1;
      wlow(8'h44);
      chk_pc("R1 latch cleared on later reset", 13'h0044);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_count();
            t_lowbyte();
            t_page();
            t_jump();
            t_ret_irq();
            t_prio();
            t_rereset();
            done = 1'b1;
         end
         begin
            repeat (200000) @(posedge clk);
            if (!done) begin
               errors++;
               $display("FAIL watchdog actual=running expected=complete");
            end
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule